// File: doc/BRIEF.md
# Multi-Slot Interrupt Status Controller

This block gathers interrupt requests from a carrier board that holds four plug-in I/O modules, each of which can raise two request lines. It keeps one control byte per slot and a 16-bit status word. From these it produces a single interrupt line toward the host. Software reaches the registers over a simple 16-bit register port: a write strobe with address and data, and a read data bus that always reflects the addressed register. Each line can be masked. Each line also chooses how it signals the host. Level lines hold the host line high until software clears them. Edge lines flip the host line for a single cycle whenever their status bit changes.

A separate acknowledge strobe stands for a read of a slot's interrupt space. It clears a pending level-mode request without a status write. Per-slot timeout event inputs latch a timeout flag that software clears by writing one to it. The same flag can also drive the host line when the slot allows it.

Top module: `slot_irq_aggregator`

## Requirements
- R1: Offset 0x00 (revision) and offset 0x0A (reset) always read 0x0000, and writes to them change nothing. Any offset that is not mapped also reads 0x0000.
- R2: The control byte of slot n (n = 0..3) sits at offset 2*(n+1) (0x02, 0x04, 0x06, 0x08). It reads back as the low 8 bits of the last value written there, with bits 15:8 reading zero. A write to one offset leaves every other slot's control byte unchanged.
- R3: Control bit 2 enables the slot's timeout flag onto the host line. Bit 4+i selects edge mode for line i. Bit 6+i enables line i. Bits 0, 1 and 3 are stored and read back but have no effect.
- R4: While a line's enable bit is 0, changes on its module input leave the status word and the host line unchanged.
- R5: The status word reads at offset 0x0C, and line i of slot n is status bit 2*n+i. On the clock edge where an enabled input is first sampled high, its bit is set. On the edge where it is first sampled low, the bit is cleared. If no status bit changes, the host line does not change.
- R6: When the status bit of an edge-mode line changes, for any reason, host_irq is inverted for exactly the one cycle after that edge.
- R7: Apart from R6 pulses, host_irq is high exactly when some set interrupt status bit belongs to a level-mode line, or when some set timeout flag belongs to a slot whose control bit 2 is 1.
- R8: Writing 1 to status bits 7:0 or 15:12 clears those bits, and writing 0 leaves them alone. Bits 11:8 always read 0, and writing to them has no effect. If an input rising edge and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: An acknowledge strobe with slot n and offset 0 clears line 0 of slot n. Offset 2 clears line 1 of that slot. The clear happens only if the line is in level mode. It has no effect on edge-mode lines or at any other offset.
- R10: A timeout event for slot n sets status bit 12+n whatever the slot's control byte holds.
- R11: After reset, all control bytes, the status word and host_irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ack_stb | input | 1 | Interrupt-space read acknowledge strobe |
| ack_slot | input | 2 | Slot addressed by the acknowledge |
| ack_off | input | 6 | Interrupt-space offset of the acknowledge |
| mod_irq | input | 8 | Module request levels, bit 2*n+i = slot n line i |
| tmo_evt | input | 4 | Per-slot timeout event pulses |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
A corrupted status bit shows up at the next read of offset 0x0C. If the line is in level mode, it also shows on host_irq in the same cycle the register takes the wrong value. A pulse that was lost or added on an edge-mode line is visible only during the single cycle after the status edge. The bench therefore samples host_irq in that exact cycle and again in the cycle after it. A stale input-history register does not show until the next input transition. It then shows as a missing or extra set, so each input toggle is followed by a status read.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
    localparam int NSLOT    = 4;
    localparam int NLINE    = 2;
    localparam int NSRC     = NSLOT * NLINE;
    localparam int AW       = 8;
    localparam int DW       = 16;
    localparam int CW       = 8;
    localparam int SLOT_W   = $clog2(NSLOT);
    localparam int IOFF_W   = 6;

    // status word layout
    localparam int TMO_BASE = 12;

    // control byte fields
    localparam int CB_TMO_EN = 2;
    localparam int CB_EDGE   = 4;
    localparam int CB_EN     = 6;

    // register offsets
    localparam logic [AW-1:0] OFS_REV   = 8'h00;
    localparam logic [AW-1:0] OFS_CTRL0 = 8'h02;
    localparam logic [AW-1:0] OFS_RST   = 8'h0A;
    localparam logic [AW-1:0] OFS_STAT  = 8'h0C;

    typedef logic [NSLOT-1:0][CW-1:0] ctrl_arr_t;

    typedef struct packed {
        ctrl_arr_t ctrl;
    } bank_st_t;

    typedef struct packed {
        logic [NSRC-1:0]  irq;
        logic [NSLOT-1:0] tmo;
        logic [NSRC-1:0]  in_hist;
        logic             pulse;
    } core_st_t;
endpackage

// File: rtl/slot_ctrl_bank.sv
module slot_ctrl_bank
    import slot_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [CW-1:0]    wdata,
    output ctrl_arr_t        ctrl_q
);
    bank_st_t st_d, st_q;
    logic [NSLOT-1:0] hit;

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        localparam logic [AW-1:0] MY_OFS = OFS_CTRL0 + AW'(2 * s);
        assign hit[s] = wr_en && (addr == MY_OFS);

        assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[s] |=> $stable(ctrl_q[s]));
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NSLOT; s++) begin
            if (hit[s]) st_d.ctrl[s] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import slot_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   line_en,
    input  logic [NSRC-1:0]   line_edge,
    input  logic [NSLOT-1:0]  tmo_en,
    input  logic [NSRC-1:0]   mod_irq,
    input  logic [NSLOT-1:0]  tmo_evt,
    input  logic              clr_wr,
    input  logic [DW-1:0]     clr_mask,
    input  logic              ack_stb,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [IOFF_W-1:0] ack_off,
    output logic [DW-1:0]     status_word,
    output logic              host_irq
);
    core_st_t st_d, st_q;
    logic [NSRC-1:0]  rise, fall, ack_hit, ack_clr, w1c_irq;
    logic [NSLOT-1:0] w1c_tmo;
    logic             lvl;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar i = 0; i < NLINE; i++) begin : g_line
            localparam int K = s * NLINE + i;
            assign ack_hit[K] = ack_stb && (ack_slot == SLOT_W'(s))
                                && (ack_off == IOFF_W'(2 * i));

            assert_disabled_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!line_en[K] && !st_q.irq[K]) |=> !st_q.irq[K]);

            assert_ack_level_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_hit[K] && !line_edge[K] && !rise[K]) |=> !st_q.irq[K]);
        end
        assert_tmo_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
            tmo_evt[s] |=> st_q.tmo[s]);
    end

    assign rise    = mod_irq & ~st_q.in_hist & line_en;
    assign fall    = ~mod_irq & st_q.in_hist & line_en;
    assign ack_clr = ack_hit & ~line_edge;
    assign w1c_irq = clr_wr ? clr_mask[NSRC-1:0] : '0;
    assign w1c_tmo = clr_wr ? clr_mask[TMO_BASE +: NSLOT] : '0;

    always_comb begin
        st_d         = st_q;
        st_d.in_hist = mod_irq;
        // clears first, then sets, so a set in the same cycle wins
        st_d.irq     = (st_q.irq & ~w1c_irq & ~ack_clr & ~fall) | rise;
        st_d.tmo     = (st_q.tmo & ~w1c_tmo) | tmo_evt;
        st_d.pulse   = |((st_d.irq ^ st_q.irq) & line_edge);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word = '0;
        status_word[NSRC-1:0] = st_q.irq;
        status_word[TMO_BASE +: NSLOT] = st_q.tmo;
    end

    assign lvl      = (|(st_q.irq & ~line_edge)) | (|(st_q.tmo & tmo_en));
    assign host_irq = lvl ^ st_q.pulse;

    assert_quiet_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.irq) |-> !st_q.pulse);
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
    import slot_irq_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  ctrl_arr_t     ctrl_q,
    input  logic [DW-1:0] status_word,
    output logic [DW-1:0] rdata
);
    logic [NSLOT-1:0] sel;

    for (genvar s = 0; s < NSLOT; s++) begin : g_sel
        assign sel[s] = (addr == (OFS_CTRL0 + AW'(2 * s)));
    end

    // revision, reset and unmapped offsets fall through to zero
    always_comb begin
        rdata = '0;
        if (addr == OFS_STAT) rdata = status_word;
        for (int s = 0; s < NSLOT; s++) begin
            if (sel[s]) rdata = {{(DW-CW){1'b0}}, ctrl_q[s]};
        end
    end
endmodule

// File: rtl/slot_irq_aggregator.sv
module slot_irq_aggregator
    import slot_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ack_stb,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [IOFF_W-1:0] ack_off,
    input  logic [NSRC-1:0]   mod_irq,
    input  logic [NSLOT-1:0]  tmo_evt,
    output logic              host_irq
);
    ctrl_arr_t        ctrl_q;
    logic [NSRC-1:0]  line_en, line_edge;
    logic [NSLOT-1:0] tmo_en;
    logic [DW-1:0]    status_word;
    logic             clr_wr;

    for (genvar s = 0; s < NSLOT; s++) begin : g_fields
        assign tmo_en[s] = ctrl_q[s][CB_TMO_EN];
        for (genvar i = 0; i < NLINE; i++) begin : g_line
            assign line_en[s*NLINE+i]   = ctrl_q[s][CB_EN + i];
            assign line_edge[s*NLINE+i] = ctrl_q[s][CB_EDGE + i];
        end
    end

    assign clr_wr = bus_wr && (bus_addr == OFS_STAT);

    slot_ctrl_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata[CW-1:0]),
        .ctrl_q (ctrl_q)
    );

    irq_status_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_en     (line_en),
        .line_edge   (line_edge),
        .tmo_en      (tmo_en),
        .mod_irq     (mod_irq),
        .tmo_evt     (tmo_evt),
        .clr_wr      (clr_wr),
        .clr_mask    (bus_wdata),
        .ack_stb     (ack_stb),
        .ack_slot    (ack_slot),
        .ack_off     (ack_off),
        .status_word (status_word),
        .host_irq    (host_irq)
    );

    reg_read_mux u_rmux (
        .addr        (bus_addr),
        .ctrl_q      (ctrl_q),
        .status_word (status_word),
        .rdata       (bus_rdata)
    );
endmodule

// File: tb/slot_irq_aggregator_tb_top.sv
module slot_irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ack_stb = 1'b0;
    logic [1:0]  ack_slot = '0;
    logic [5:0]  ack_off = '0;
    logic [7:0]  mod_irq = '0;
    logic [3:0]  tmo_evt = '0;
    logic        host_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    slot_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_stb(ack_stb),
        .ack_slot(ack_slot), .ack_off(ack_off), .mod_irq(mod_irq),
        .tmo_evt(tmo_evt), .host_irq(host_irq)
    );

    // op: 0 write, 1 read, 2 set module inputs, 3 timeout event, 4 acknowledge {slot,off}
    // fields: op[3] addr[8] data[16] exp_rdata[16] exp_irq[1] req[4]
    localparam int NV = 43;
    localparam logic [47:0] VEC [0:NV-1] = '{
        {3'd1, 8'h0C, 16'h0000, 16'h0000, 1'b0, 4'd11}, // R11 status clear
        {3'd1, 8'h02, 16'h0000, 16'h0000, 1'b0, 4'd11}, // R11
        {3'd1, 8'h08, 16'h0000, 16'h0000, 1'b0, 4'd11}, // R11
        {3'd0, 8'h00, 16'hFFFF, 16'h0000, 1'b0, 4'd1},  // R1
        {3'd1, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 revision reads 0
        {3'd0, 8'h0A, 16'hFFFF, 16'h0000, 1'b0, 4'd1},  // R1
        {3'd1, 8'h0A, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 reset reg reads 0
        {3'd1, 8'h0E, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1 unmapped
        {3'd2, 8'h00, 16'h0001, 16'h0000, 1'b0, 4'd4},  // R4 disabled input
        {3'd1, 8'h0C, 16'h0000, 16'h0000, 1'b0, 4'd4},  // R4
        {3'd2, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd4},  // R4
        {3'd0, 8'h02, 16'h0040, 16'h0000, 1'b0, 4'd2},  // R2 slot A line0 enable
        {3'd1, 8'h02, 16'h0000, 16'h0040, 1'b0, 4'd2},  // R2
        {3'd1, 8'h04, 16'h0000, 16'h0000, 1'b0, 4'd2},  // R2 other slot untouched
        {3'd2, 8'h00, 16'h0001, 16'h0000, 1'b1, 4'd7},  // R7 level asserts
        {3'd1, 8'h0C, 16'h0000, 16'h0001, 1'b1, 4'd5},  // R5 bit0
        {3'd4, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd9},  // R9 ack level line
        {3'd1, 8'h0C, 16'h0000, 16'h0000, 1'b0, 4'd9},  // R9
        {3'd2, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd5},  // R5 fall, no change
        {3'd0, 8'h04, 16'h00A0, 16'h0000, 1'b0, 4'd2},  // R2 slot B line1 edge+en
        {3'd1, 8'h04, 16'h0000, 16'h00A0, 1'b0, 4'd2},  // R2
        {3'd2, 8'h00, 16'h0008, 16'h0000, 1'b1, 4'd6},  // R6 pulse
        {3'd1, 8'h0C, 16'h0000, 16'h0008, 1'b0, 4'd6},  // R6 pulse ended
        {3'd4, 8'h42, 16'h0000, 16'h0000, 1'b0, 4'd9},  // R9 ack edge line
        {3'd1, 8'h0C, 16'h0000, 16'h0008, 1'b0, 4'd9},  // R9 untouched
        {3'd0, 8'h0C, 16'h0008, 16'h0000, 1'b1, 4'd8},  // R8 clear -> pulse
        {3'd1, 8'h0C, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8
        {3'd2, 8'h00, 16'h0000, 16'h0000, 1'b0, 4'd5},  // R5 quiet
        {3'd3, 8'h00, 16'h0004, 16'h0000, 1'b0, 4'd10}, // R10 slot C timeout
        {3'd1, 8'h0C, 16'h0000, 16'h4000, 1'b0, 4'd10}, // R10
        {3'd0, 8'h06, 16'h0004, 16'h0000, 1'b1, 4'd10}, // R10 enable onto output
        {3'd1, 8'h06, 16'h0000, 16'h0004, 1'b1, 4'd3},  // R3
        {3'd0, 8'h0C, 16'h0F00, 16'h0000, 1'b1, 4'd8},  // R8 error bits
        {3'd1, 8'h0C, 16'h0000, 16'h4000, 1'b1, 4'd8},  // R8
        {3'd0, 8'h0C, 16'h4000, 16'h0000, 1'b0, 4'd8},  // R8 clear timeout
        {3'd1, 8'h0C, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8
        {3'd0, 8'h08, 16'h000B, 16'h0000, 1'b0, 4'd3},  // R3 inert bits
        {3'd1, 8'h08, 16'h0000, 16'h000B, 1'b0, 4'd3},  // R3
        {3'd3, 8'h00, 16'h0008, 16'h0000, 1'b0, 4'd3},  // R3 bit3 not timeout enable
        {3'd1, 8'h0C, 16'h0000, 16'h8000, 1'b0, 4'd10}, // R10
        {3'd0, 8'h0C, 16'h8000, 16'h0000, 1'b0, 4'd8},  // R8
        {3'd0, 8'h02, 16'hFF40, 16'h0000, 1'b0, 4'd2},  // R2 upper byte
        {3'd1, 8'h02, 16'h0000, 16'h0040, 1'b0, 4'd2}   // R2
    };

    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_strobes();
        bus_wr = 1'b0; ack_stb = 1'b0; tmo_evt = '0;
    endtask

    task automatic run_vec(input logic [47:0] v);
        logic [2:0] op;
        op = v[47:45];
        case (op)
            3'd0: begin bus_wr = 1'b1; bus_addr = v[44:37]; bus_wdata = v[36:21]; end
            3'd1: bus_addr = v[44:37];
            3'd2: mod_irq = v[28:21];
            3'd3: tmo_evt = v[24:21];
            default: begin ack_stb = 1'b1; ack_slot = v[44:43]; ack_off = v[42:37]; end
        endcase
        @(negedge clk);
        if (op == 3'd1) chk(int'(v[3:0]), "rdata", bus_rdata, v[20:5]);
        chk(int'(v[3:0]), "host_irq", {15'd0, host_irq}, {15'd0, v[4]});
        idle_strobes();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(11, "host_irq after reset", {15'd0, host_irq}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
        end

        // R8: input rising edge and write-one-clear on the same bit, set wins
        mod_irq = 8'h01; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 16'h0001;
        @(negedge clk);
        idle_strobes();
        chk(8, "set beats clear", bus_rdata, 16'h0001);
        chk(7, "level high", {15'd0, host_irq}, 16'd1);

        // R6: edge line change while a level line is active inverts the output
        mod_irq = 8'h09;
        @(negedge clk);
        chk(6, "inverted pulse", {15'd0, host_irq}, 16'd0);
        chk(5, "both bits", bus_rdata, 16'h0009);
        @(negedge clk);
        chk(6, "after pulse", {15'd0, host_irq}, 16'd1);

        // R9: acknowledge at an offset other than 0 or 2 is ignored
        ack_stb = 1'b1; ack_slot = 2'd0; ack_off = 6'd4;
        @(negedge clk);
        idle_strobes();
        chk(9, "odd ack offset", bus_rdata, 16'h0009);
        chk(9, "odd ack irq", {15'd0, host_irq}, 16'd1);

        // R11: reset mid-run clears everything
        mod_irq = '0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(11, "status after reset", bus_rdata, 16'h0000);
        chk(11, "irq after reset", {15'd0, host_irq}, 16'd0);
        bus_addr = 8'h04;
        @(negedge clk);
        chk(11, "ctrl B after reset", bus_rdata, 16'h0000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule